// File: doc/BRIEF.md
# Accumulator Machine with ROM Bootstrap

This block is a compact 8-bit accumulator processor with one 256-word RAM that holds both code and data. When reset is released, it first loads a built-in ROM image into the RAM. It copies one word on each clock, and the program counter serves as the copy address. When that counter wraps from its last address back to zero, the bootstrap-done flag rises. Execution then begins at address 0.

Every instruction takes two words: an opcode word, then the operand word stored just after it. The processor moves through three steps for each instruction: fetch the opcode, fetch the operand, and execute. Once the image is loaded, each step happens only on a clock where the step-enable input is high, so a slow external strobe can single-step the machine. The bootstrap copy ignores step-enable and runs at full clock rate. A STORE may overwrite an operand word, and this is how programs keep loop counters and running totals inside their own immediates. The `PROGRAM` parameter selects the ROM image. Image 0 sums the digits down from nine using self-modifying code. Image 1 exercises wrap-around, an unknown opcode, and both outcomes of the branch.

Top module: `acc_machine`

## Requirements
- R1: After reset is released, `state` stays 0 and `boot_done` stays low for exactly 256 clock edges, whatever `step_en` does. `boot_done` goes high after the 256th edge and stays high until the next reset.
- R2: `state` encodes the phase as 0 = bootstrap, 1 = fetch opcode, 2 = fetch operand, 3 = execute. Execution enters state 1 with the first fetch taken from address 0.
- R3: After bootstrap, `state` steps 1 -> 2 -> 3 -> 1 only on edges where `step_en` is high. With `step_en` low, the state, the program counter and `acc` all hold. `acc` changes only on an execute edge.
- R4: Opcode 8'h04 (clear) sets `acc` to 0 and ignores its operand word.
- R5: Opcode 8'h01 adds the operand word to `acc`, and opcode 8'h02 subtracts it. Both are modulo 256, and no flag is kept.
- R6: Opcode 8'h10 (store) writes `acc` to the RAM address named by its operand and leaves `acc` unchanged. Any later fetch of that word, including an instruction's operand slot, returns the stored value.
- R7: Opcode 8'h08 loads the program counter with the operand when `acc` is 0. Otherwise execution continues at the word after the operand.
- R8: Any other opcode value leaves `acc` unchanged. It still consumes its operand word and does not change the flow of the program.
- R9: Synchronous reset forces `state` to 0, `boot_done` low, `acc` to 0 and the program counter to 0 on the next edge. A fresh bootstrap then follows, and the program restarts from address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advances execution by one phase when high (ignored during bootstrap) |
| boot_done | output | 1 | Sticky flag, high once the ROM copy has wrapped the address counter |
| acc | output | 8 | Accumulator value |
| state | output | 2 | Phase indicator: 0 bootstrap, 1 fetch opcode, 2 fetch operand, 3 execute |

## Verification
The properties assume that `rst` is held high for at least one sampled edge before any other check matters. They also assume that `step_en` is a clean synchronous level that changes only between edges, because the hold and sequencing properties read its value at each edge. The bench drives `step_en` and `rst` one nanosecond after a rising edge and compares outputs on the falling edge, so every input it applies is a settled level at the following edge. It holds `step_en` low through one bootstrap and high through another, to show that the copy ignores it. It also inserts a long low stretch in the middle of a program to observe the hold.

// File: rtl/acc_machine.sv
module acc_machine #(
  parameter int W       = 8,
  parameter int AW      = 8,
  parameter int PROGRAM = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_en,
  output logic         boot_done,
  output logic [W-1:0] acc,
  output logic [1:0]   state
);
  localparam int DEPTH = 1 << AW;
  localparam logic [W-1:0] OP_ADD = W'(8'h01);
  localparam logic [W-1:0] OP_SUB = W'(8'h02);
  localparam logic [W-1:0] OP_CLR = W'(8'h04);
  localparam logic [W-1:0] OP_BZ  = W'(8'h08);
  localparam logic [W-1:0] OP_STO = W'(8'h10);
  localparam logic [1:0] S_BOOT = 2'd0, S_OPC = 2'd1, S_ARG = 2'd2, S_EXE = 2'd3;

  logic [W-1:0]  ram [DEPTH];
  logic [AW-1:0] pc;
  logic [W-1:0]  opc, arg;

  function automatic logic [W-1:0] rom_word(input logic [AW-1:0] a);
    rom_word = '0;
    if (PROGRAM == 0) begin
      case (int'(a))
        0:  rom_word = OP_CLR;
        2:  rom_word = OP_ADD;  3:  rom_word = W'(10);
        4:  rom_word = OP_SUB;  5:  rom_word = W'(1);
        6:  rom_word = OP_STO;  7:  rom_word = W'(3);
        8:  rom_word = OP_BZ;   9:  rom_word = W'(22);
        10: rom_word = OP_ADD;  11: rom_word = W'(0);
        12: rom_word = OP_STO;  13: rom_word = W'(11);
        14: rom_word = OP_STO;  15: rom_word = W'(100);
        16: rom_word = OP_CLR;
        18: rom_word = OP_BZ;   19: rom_word = W'(2);
        22: rom_word = OP_CLR;
        24: rom_word = OP_BZ;   25: rom_word = W'(22);
        default: rom_word = '0;
      endcase
    end else begin
      case (int'(a))
        0:  rom_word = OP_CLR;
        2:  rom_word = OP_SUB;  3:  rom_word = W'(3);
        4:  rom_word = W'(8'hFF); 5: rom_word = W'(7);
        6:  rom_word = OP_ADD;  7:  rom_word = W'(3);
        8:  rom_word = OP_BZ;   9:  rom_word = W'(12);
        10: rom_word = OP_ADD;  11: rom_word = W'(99);
        12: rom_word = OP_ADD;  13: rom_word = W'(200);
        14: rom_word = OP_ADD;  15: rom_word = W'(100);
        16: rom_word = OP_BZ;   17: rom_word = W'(0);
        18: rom_word = OP_STO;  19: rom_word = W'(19);
        20: rom_word = OP_CLR;
        22: rom_word = OP_BZ;   23: rom_word = W'(20);
        default: rom_word = '0;
      endcase
    end
  endfunction

  logic exe_now, last_boot;
  assign exe_now   = boot_done && step_en && (state == S_EXE);
  assign last_boot = (pc == AW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!rst && !boot_done)
      ram[pc] <= rom_word(pc);
    else if (!rst && exe_now && opc == OP_STO)
      ram[arg[AW-1:0]] <= acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_BOOT;
      boot_done <= 1'b0;
      pc        <= '0;
      acc       <= '0;
      opc       <= '0;
      arg       <= '0;
    end else if (!boot_done) begin
      pc <= pc + 1'b1;
      if (last_boot) begin
        boot_done <= 1'b1;
        state     <= S_OPC;
      end
    end else if (step_en) begin
      case (state)
        S_OPC: begin
          opc   <= ram[pc];
          pc    <= pc + 1'b1;
          state <= S_ARG;
        end
        S_ARG: begin
          arg   <= ram[pc];
          pc    <= pc + 1'b1;
          state <= S_EXE;
        end
        S_EXE: begin
          state <= S_OPC;
          case (opc)
            OP_CLR:  acc <= '0;
            OP_ADD:  acc <= acc + arg;
            OP_SUB:  acc <= acc - arg;
            OP_BZ:   if (acc == '0) pc <= arg[AW-1:0];
            default: ;
          endcase
        end
        default: state <= S_BOOT;
      endcase
    end
  end
endmodule

// File: rtl/acc_machine_chk.sv
module acc_machine_chk #(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         step_en,
  input logic         boot_done,
  input logic [W-1:0] acc,
  input logic [1:0]   state,
  input logic [W-1:0] opc,
  input logic [W-1:0] arg
);
  logic exe;
  assign exe = boot_done && step_en && (state == 2'd3);

  p_boot_state_r1: assert property (@(posedge clk) disable iff (rst)
    !boot_done |-> state == 2'd0);
  p_done_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    boot_done |=> boot_done);
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(boot_done) |-> state == 2'd1);
  p_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (boot_done && !step_en) |=> ($stable(state) && $stable(acc)));
  p_seq_op_r3: assert property (@(posedge clk) disable iff (rst)
    (boot_done && step_en && state == 2'd1) |=> state == 2'd2);
  p_seq_arg_r3: assert property (@(posedge clk) disable iff (rst)
    (boot_done && step_en && state == 2'd2) |=> state == 2'd3);
  p_seq_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    exe |=> state == 2'd1);
  p_acc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (state != 2'd3) |=> $stable(acc));
  p_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (exe && opc == W'(8'h04)) |=> acc == '0);
  p_add_r5: assert property (@(posedge clk) disable iff (rst)
    (exe && opc == W'(8'h01)) |=> acc == W'($past(acc) + $past(arg)));
  p_sub_r5: assert property (@(posedge clk) disable iff (rst)
    (exe && opc == W'(8'h02)) |=> acc == W'($past(acc) - $past(arg)));
  // R6, R7 and R8: every opcode outside add/sub/clear keeps the accumulator
  p_keep_acc_r8: assert property (@(posedge clk) disable iff (rst)
    (exe && opc != W'(8'h01) && opc != W'(8'h02) && opc != W'(8'h04)) |=> $stable(acc));
  p_reset_r9: assert property (@(posedge clk)
    rst |=> (state == 2'd0 && !boot_done && acc == '0));
endmodule

bind acc_machine acc_machine_chk #(.W(W), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .step_en(step_en), .boot_done(boot_done),
  .acc(acc), .state(state), .opc(opc), .arg(arg)
);

// File: tb/acc_machine_tb_top.sv
`timescale 1ns/1ps
module acc_machine_tb_top;
  logic clk = 1'b0, rst = 1'b1, step_en = 1'b0;
  always #2 clk = ~clk;

  logic       bd0, bd1;
  logic [7:0] acc0, acc1, e, held_acc0, held_acc1;
  logic [1:0] st0, st1, held_st0;

  acc_machine #(.PROGRAM(0)) dut_i (.clk(clk), .rst(rst), .step_en(step_en),
    .boot_done(bd0), .acc(acc0), .state(st0));
  acc_machine #(.PROGRAM(1)) dut_t_i (.clk(clk), .rst(rst), .step_en(step_en),
    .boot_done(bd1), .acc(acc1), .state(st1));

  int n_chk = 0, n_bad = 0, cycles = 0;
  bit mon_on = 0, pend0 = 0, pend1 = 0, boot_ok = 1;
  logic [7:0] q0[$], q1[$];

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // Driver: expected accumulator after each execute step, self-modifying digit sum (R6, R7)
  task automatic push_prog0();
    int s = 0, idx = 10;
    q0.push_back(8'd0);
    forever begin
      q0.push_back(8'(idx));
      idx--;
      repeat (3) q0.push_back(8'(idx));
      if (idx == 0) break;
      s += idx;
      repeat (3) q0.push_back(8'(s));
      repeat (2) q0.push_back(8'd0);
    end
    repeat (4) q0.push_back(8'd0);
  endtask

  // Driver: wrap-around (R5), unknown opcode (R8), branch taken and not taken (R7), clear (R4)
  task automatic push_prog1();
    q1.push_back(8'd0);   q1.push_back(8'd253); q1.push_back(8'd253);
    q1.push_back(8'd0);   q1.push_back(8'd0);   q1.push_back(8'd200);
    q1.push_back(8'd44);  q1.push_back(8'd44);  q1.push_back(8'd44);
    repeat (6) q1.push_back(8'd0);
  endtask

  // Monitor: pops one expected value per executed instruction
  always @(negedge clk) begin
    if (mon_on) begin
      if (pend0 && q0.size() > 0) begin
        e = q0.pop_front();
        check(acc0 == e, "R4/R5/R6/R7 digit-sum trace", acc0, e);
      end
      if (pend1 && q1.size() > 0) begin
        e = q1.pop_front();
        check(acc1 == e, "R4/R5/R7/R8 corner trace", acc1, e);
      end
      pend0 = (st0 == 2'd3) && step_en;
      pend1 = (st1 == 2'd3) && step_en;
    end else begin
      pend0 = 0;
      pend1 = 0;
    end
  end

  task automatic count_boot();
    cycles = 0;
    boot_ok = 1;
    while (!bd0 && cycles < 1000) begin
      @(posedge clk); #1;
      cycles++;
      if (!bd0 && (st0 != 2'd0 || acc0 != 8'd0)) boot_ok = 0;
    end
  endtask

  task automatic run_until_empty(input int limit);
    for (int i = 0; i < limit && (q0.size() > 0 || q1.size() > 0); i++) begin
      @(posedge clk); #1;
      step_en = (i % 5 != 3);
      if (i == 200) begin
        step_en = 0;
        held_acc0 = acc0; held_acc1 = acc1; held_st0 = st0;
        repeat (12) @(posedge clk);
        #1;
        check(acc0 == held_acc0, "R3 acc hold with step low", acc0, held_acc0);
        check(acc1 == held_acc1, "R3 acc hold with step low (corner)", acc1, held_acc1);
        check(st0 == held_st0, "R3 state hold with step low", st0, held_st0);
      end
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(st0 == 2'd0, "R9 reset state", st0, 0);
    check(bd0 == 1'b0, "R9 reset boot_done", bd0, 0);
    check(acc0 == 8'd0, "R9 reset acc", acc0, 0);

    @(posedge clk); #1 rst = 0;
    count_boot();
    check(cycles == 256, "R1 bootstrap length", cycles, 256);
    check(boot_ok, "R1 state and acc idle during bootstrap", boot_ok, 1);
    check(bd1 == 1'b1, "R1 boot_done on second instance", bd1, 1);
    check(st0 == 2'd1, "R2 first phase after bootstrap", st0, 1);
    @(posedge clk); #1;
    check(bd0 == 1'b1, "R1 boot_done sticky", bd0, 1);

    push_prog0();
    push_prog1();
    mon_on = 1;
    run_until_empty(4000);
    check(q0.size() == 0, "R6 digit-sum trace completed", q0.size(), 0);
    check(q1.size() == 0, "R8 corner trace completed", q1.size(), 0);

    mon_on = 0;
    @(posedge clk); #1 rst = 1; step_en = 1;
    @(posedge clk); #1;
    check(st0 == 2'd0, "R9 mid-run reset state", st0, 0);
    check(bd0 == 1'b0, "R9 mid-run reset boot_done", bd0, 0);
    rst = 0;
    count_boot();
    check(cycles == 256, "R1 bootstrap length with step high", cycles, 256);
    check(boot_ok, "R1 step_en ignored during bootstrap", boot_ok, 1);

    q0.delete();
    push_prog1();
    mon_on = 1;
    run_until_empty(500);
    check(q1.size() == 0, "R9 restart from address 0", q1.size(), 0);
    mon_on = 0;

    summary();
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule